// File: doc/BRIEF.md
# Flash Chip-Erase Sequencer

This block drives a byte-wide flash array through its command register and runs a complete chip erase on one start pulse. It first programs every byte to 00h through a program request/acknowledge pair. That step stands for the per-byte programming routine. It then writes the erase code twice: the first write arms the erase and the second starts it. It holds off for a fixed erase pulse time and then walks the array with verify cycles. Each verify cycle is a command write of A0h carrying the byte address, followed by a read of that byte.

A byte that reads back as anything other than FFh triggers a new erase. Checking then resumes at that same byte, because every byte below it has already verified. The number of erase pulses is limited. When the limit is used up and a byte still fails, the sequencer writes the reset command and raises `fail`. When every byte has verified, it writes the reset command and raises `done`.

Top module: `flash_erase_seq`

## Requirements
- R1: After a synchronous reset, `mem_wr`, `mem_rd`, `prog_req`, `done` and `fail` are all low.
- R2: After `start`, the block raises `prog_req` with `mem_wdata` = 00h for every address from 0 up to the last one, in ascending order. Each request holds until `prog_ack` is seen, and no command write happens before the last byte is acknowledged.
- R3: An erase is two command writes of 20h on consecutive cycles. The first arms the erase and the second starts it.
- R4: After the second 20h write there are exactly `HOLD_CYC` cycles with no strobe. The verify write then comes in the cycle after those.
- R5: A verify writes A0h with the byte address on `mem_addr`. In the next cycle it strobes `mem_rd` at the same address. The block samples `mem_rdata` in the cycle after the read strobe.
- R6: A verify that reads FFh moves to the next address. When it reads FFh at the last address, the block writes the reset command FFh.
- R7: A verify that reads any value other than FFh causes a new erase (R3, R4), provided the pulse limit is not reached. Verification then continues at the failing address, not at address 0.
- R8: If a verify fails after `MAX_PULSES` erase pulses have been issued, no further erase is issued. The block writes the reset command FFh, then raises `fail` and never `done`.
- R9: `done` rises only in the cycle after the reset command write of a fully verified run. `done` and `fail` stay high until the next `start`, and that `start` clears them.
- R10: `start` is ignored while a run is in progress.
- R11: At most one of `mem_wr`, `mem_rd`, `prog_req` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a chip erase when idle, done or failed |
| done | output | 1 | Erase completed and verified |
| fail | output | 1 | Pulse limit exhausted before all bytes verified |
| mem_addr | output | AW | Byte address for program, verify write and read |
| mem_wdata | output | 8 | Command code, or 00h during program requests |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| mem_wr | output | 1 | Command register write strobe |
| mem_rd | output | 1 | Byte read strobe |
| prog_req | output | 1 | Request to program `mem_addr` with `mem_wdata` |
| prog_ack | input | 1 | Program request accepted |

## Verification
The bench builds the block with an 8-byte array, a 3-cycle erase hold and a limit of 3 pulses. Those small values make it cheap to reach several cases:
- a run that needs exactly the maximum number of pulses;
- a failing byte at the last address;
- a byte that never erases, which drives the fail path.

The small array keeps every whole bus transaction sequence short enough to predict completely and compare strobe by strobe. The bench also pokes `start` during pre-programming to show that it has no effect.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PREP,
    ST_ESET,
    ST_ECNF,
    ST_EHOLD,
    ST_VSET,
    ST_VRD,
    ST_VCHK,
    ST_RCMD,
    ST_DONE,
    ST_FAIL
  } seq_state_t;

  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_VERIFY  = 8'hA0;
  localparam logic [7:0] CMD_RESET   = 8'hFF;
  localparam logic [7:0] BYTE_ERASED = 8'hFF;
  localparam logic [7:0] BYTE_ZERO   = 8'h00;

endpackage

// File: rtl/fes_addr_walker.sv
module fes_addr_walker #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic [AW-1:0] addr,
  output logic          at_last
);
  localparam logic [AW-1:0] LAST = {AW{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr) addr <= '0;
    else if (inc)   addr <= addr + 1'b1;
  end

  assign at_last = (addr == LAST);

  // the sequencer must never step past the top of the array
  p_walk_no_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    inc |-> !at_last);
endmodule

// File: rtl/fes_hold_timer.sv
module fes_hold_timer #(
  parameter int CYC = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expired
);
  localparam int TW = (CYC < 2) ? 1 : $clog2(CYC + 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)           cnt <= '0;
    else if (load)     cnt <= TW'(CYC - 1);
    else if (cnt != 0) cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == 0);

  // a new pulse is only started once the previous hold has run out
  p_no_reload_running_r4: assert property (@(posedge clk) disable iff (rst)
    load |-> expired);
endmodule

// File: rtl/fes_pulse_budget.sv
module fes_pulse_budget #(
  parameter int MAX_PULSES = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic bump,
  output logic spent
);
  localparam int CW = $clog2(MAX_PULSES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (bump)  cnt <= cnt + 1'b1;
  end

  assign spent = (cnt == CW'(MAX_PULSES));

  // the sequencer never issues a pulse beyond the budget
  p_budget_cap_r8: assert property (@(posedge clk) disable iff (rst)
    bump |-> !spent);
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import flash_erase_pkg::*;
#(
  parameter int AW         = 10,
  parameter int HOLD_CYC   = 50,
  parameter int MAX_PULSES = 100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          done,
  output logic          fail,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  output logic          mem_wr,
  output logic          mem_rd,
  output logic          prog_req,
  input  logic          prog_ack
);

  seq_state_t state, nxt;
  logic walk_clr, walk_inc, at_last;
  logic hold_load, hold_done;
  logic bud_clr, bud_bump, spent;
  logic fail_set, fail_q;

  fes_addr_walker #(.AW(AW)) u_walk (
    .clk(clk), .rst(rst), .clr(walk_clr), .inc(walk_inc),
    .addr(mem_addr), .at_last(at_last)
  );

  fes_hold_timer #(.CYC(HOLD_CYC)) u_hold (
    .clk(clk), .rst(rst), .load(hold_load), .expired(hold_done)
  );

  fes_pulse_budget #(.MAX_PULSES(MAX_PULSES)) u_budget (
    .clk(clk), .rst(rst), .clr(bud_clr), .bump(bud_bump), .spent(spent)
  );

  always_comb begin
    nxt       = state;
    walk_clr  = 1'b0;
    walk_inc  = 1'b0;
    hold_load = 1'b0;
    bud_bump  = 1'b0;
    bud_clr   = 1'b0;
    fail_set  = 1'b0;
    unique case (state)
      ST_IDLE, ST_DONE, ST_FAIL: begin
        if (start) begin
          nxt      = ST_PREP;
          walk_clr = 1'b1;
          bud_clr  = 1'b1;
        end
      end
      ST_PREP: begin
        if (prog_ack) begin
          if (at_last) begin
            nxt      = ST_ESET;
            walk_clr = 1'b1;
          end else begin
            walk_inc = 1'b1;
          end
        end
      end
      ST_ESET: nxt = ST_ECNF;
      ST_ECNF: begin
        nxt       = ST_EHOLD;
        hold_load = 1'b1;
        bud_bump  = 1'b1;
      end
      ST_EHOLD: if (hold_done) nxt = ST_VSET;
      ST_VSET:  nxt = ST_VRD;
      ST_VRD:   nxt = ST_VCHK;
      ST_VCHK: begin
        if (mem_rdata == BYTE_ERASED) begin
          if (at_last) begin
            nxt = ST_RCMD;
          end else begin
            walk_inc = 1'b1;
            nxt      = ST_VSET;
          end
        end else if (spent) begin
          nxt      = ST_RCMD;
          fail_set = 1'b1;
        end else begin
          nxt = ST_ESET;
        end
      end
      ST_RCMD: nxt = fail_q ? ST_FAIL : ST_DONE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      mem_wr    <= 1'b0;
      mem_rd    <= 1'b0;
      prog_req  <= 1'b0;
      mem_wdata <= BYTE_ZERO;
      done      <= 1'b0;
      fail      <= 1'b0;
      fail_q    <= 1'b0;
    end else begin
      state    <= nxt;
      mem_wr   <= (nxt == ST_ESET) || (nxt == ST_ECNF) ||
                  (nxt == ST_VSET) || (nxt == ST_RCMD);
      mem_rd   <= (nxt == ST_VRD);
      prog_req <= (nxt == ST_PREP);
      done     <= (nxt == ST_DONE);
      fail     <= (nxt == ST_FAIL);
      if (bud_clr)       fail_q <= 1'b0;
      else if (fail_set) fail_q <= 1'b1;
      case (nxt)
        ST_ESET, ST_ECNF: mem_wdata <= CMD_ERASE;
        ST_VSET:          mem_wdata <= CMD_VERIFY;
        ST_RCMD:          mem_wdata <= CMD_RESET;
        default:          mem_wdata <= BYTE_ZERO;
      endcase
    end
  end

  p_one_strobe_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_wr, mem_rd, prog_req}));

  p_verify_then_read_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && mem_wdata == CMD_VERIFY) |=> (mem_rd && $stable(mem_addr)));

  p_setup_confirm_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ESET) |=> (mem_wr && mem_wdata == CMD_ERASE));

  p_quiet_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EHOLD) |-> !(mem_wr || mem_rd || prog_req));

  p_done_after_reset_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(mem_wr && mem_wdata == CMD_RESET));

  p_flags_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(done && fail));

  p_busy_ignores_start_r10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_VCHK && start) |=> (state != ST_PREP));

endmodule

// File: tb/flash_erase_seq_test.sv
`timescale 1ns/1ps
module flash_erase_seq_test;
  localparam int AW   = 3;
  localparam int D    = 8;
  localparam int HOLD = 3;
  localparam int MAXP = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic done, fail, mem_wr, mem_rd, prog_req;
  logic prog_ack = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata = 8'h00;

  always #2.5 clk = ~clk;

  flash_erase_seq #(.AW(AW), .HOLD_CYC(HOLD), .MAX_PULSES(MAXP)) uut (
    .clk(clk), .rst(rst), .start(start), .done(done), .fail(fail),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_wr(mem_wr), .mem_rd(mem_rd), .prog_req(prog_req), .prog_ack(prog_ack)
  );

  int checks = 0;
  int errors = 0;
  int need [D];
  int pulses_done = 0;
  bit armed = 0;
  bit model_clr = 0;
  int cyc = 0;

  // expected transactions: kind 0 = program, 1 = command write, 2 = read
  int    q_kind [$];
  int    q_addr [$];
  int    q_data [$];
  string q_tag  [$];
  bit    final_fail;

  // flash array model
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (model_clr) begin
      pulses_done <= 0;
      armed <= 0;
    end else if (mem_wr) begin
      if (mem_wdata == 8'h20) begin
        if (armed) begin
          pulses_done <= pulses_done + 1;
          armed <= 0;
        end else armed <= 1;
      end else armed <= 0;
    end
    if (mem_rd) mem_rdata <= (pulses_done >= need[mem_addr]) ? 8'hFF : 8'h00;
  end

  task automatic push(int k, int a, int d, string t);
    q_kind.push_back(k); q_addr.push_back(a); q_data.push_back(d); q_tag.push_back(t);
  endtask

  task automatic build();
    int p = 0;
    int a = 0;
    q_kind.delete(); q_addr.delete(); q_data.delete(); q_tag.delete();
    final_fail = 0;
    for (int i = 0; i < D; i++) push(0, i, 8'h00, "R2");
    push(1, -1, 8'h20, "R3"); push(1, -1, 8'h20, "R3"); p = 1;
    while (a < D) begin
      push(1, a, 8'hA0, "R5");
      push(2, a, 0, "R5");
      if (p >= need[a]) a++;
      else if (p == MAXP) begin final_fail = 1; break; end
      else begin
        push(1, -1, 8'h20, "R7"); push(1, -1, 8'h20, "R7"); p++;
      end
    end
    push(1, -1, 8'hFF, final_fail ? "R8" : "R6");
  endtask

  bit mon_en = 0;
  bit exp_done = 0, exp_fail = 0, exp_idle = 1;
  bit pend_done = 0, pend_fail = 0, pend_clr = 0;
  bit set_seen = 0, gap_armed = 0;
  int cnf_cyc = 0;
  int ackc = 0;

  task automatic take(int k, int a, int d);
    checks++;
    if (q_kind.size() == 0) begin
      errors++;
      $display("FAIL R11 unexpected kind=%0d addr=%0d data=%h, expected no activity", k, a, d);
      return;
    end
    begin
      int ek = q_kind.pop_front();
      int ea = q_addr.pop_front();
      int ed = q_data.pop_front();
      string et = q_tag.pop_front();
      if (ek != k || (ea >= 0 && ea != a) || (k != 2 && ed != d)) begin
        errors++;
        $display("FAIL %s actual kind=%0d addr=%0d data=%h expected kind=%0d addr=%0d data=%h",
                 et, k, a, d, ek, ea, ed);
      end
    end
    if (k == 1 && d == 8'h20) begin
      if (set_seen) begin set_seen = 0; gap_armed = 1; cnf_cyc = cyc; end
      else set_seen = 1;
    end else set_seen = 0;
    if (k == 1 && d == 8'hA0 && gap_armed) begin
      gap_armed = 0;
      checks++;
      if (cyc - cnf_cyc != HOLD + 1) begin
        errors++;
        $display("FAIL R4 hold gap actual=%0d expected=%0d", cyc - cnf_cyc, HOLD + 1);
      end
    end
    if (k == 1 && d == 8'hFF) begin
      if (final_fail) pend_fail = 1; else pend_done = 1;
    end
  endtask

  always @(negedge clk) begin
    if (mon_en) begin
      if (pend_clr) begin exp_done = 0; exp_fail = 0; exp_idle = 0; pend_clr = 0; end
      if (pend_done) begin exp_done = 1; pend_done = 0; end
      if (pend_fail) begin exp_fail = 1; pend_fail = 0; end
      checks++;
      if (done !== exp_done || fail !== exp_fail) begin
        errors++;
        $display("FAIL R9 done/fail actual=%b%b expected=%b%b", done, fail, exp_done, exp_fail);
      end
      if (start && (exp_idle || exp_done || exp_fail)) pend_clr = 1;
      if (mem_wr) take(1, int'(mem_addr), int'(mem_wdata));
      if (mem_rd) take(2, int'(mem_addr), 0);
      if (prog_req && !prog_ack) begin
        checks++;
        if (mem_wdata !== 8'h00) begin
          errors++;
          $display("FAIL R2 program data actual=%h expected=00", mem_wdata);
        end
        ackc++;
        if (ackc >= 2) begin
          ackc = 0;
          prog_ack = 1;
          take(0, int'(mem_addr), 0);
        end
      end else prog_ack = 0;
    end
  end

  task automatic pulse_start();
    @(posedge clk); #1 start = 1;
    @(posedge clk); #1 start = 0;
  endtask

  task automatic run(string name, bit poke);
    int t = 0;
    @(posedge clk); #1 model_clr = 1;
    @(posedge clk); #1 model_clr = 0;
    build();
    pulse_start();
    if (poke) begin
      repeat (4) @(posedge clk);
      #1 start = 1;  // R10: start during pre-programming must have no effect
      @(posedge clk); #1 start = 0;
    end
    while (!(done || fail) && t < 3000) begin @(negedge clk); t++; end
    if (t >= 3000) begin
      errors++; checks++;
      $display("FAIL R9 %s watchdog actual=timeout expected=finished", name);
    end
    repeat (6) @(negedge clk);
    checks++;
    if (q_kind.size() != 0) begin
      errors++;
      $display("FAIL R10 %s leftover transactions actual=%0d expected=0", name, q_kind.size());
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL R9 global watchdog actual=expired expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < D; i++) need[i] = 1;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    checks++;  // R1
    if ({mem_wr, mem_rd, prog_req, done, fail} !== 5'b0) begin
      errors++;
      $display("FAIL R1 reset outputs actual=%b expected=00000", {mem_wr, mem_rd, prog_req, done, fail});
    end
    mon_en = 1;

    // single pulse, start poked while busy (R10)
    run("single", 1);

    // re-erase resuming at bytes 2 and 5, ending at the limit (R7)
    for (int i = 0; i < D; i++) need[i] = 1;
    need[2] = 2; need[5] = 3;
    run("resume", 0);

    // failure at the last address recovered by a second pulse (R7, R6)
    for (int i = 0; i < D; i++) need[i] = 1;
    need[7] = 2;
    run("last", 0);

    // a byte that never erases within the budget (R8)
    for (int i = 0; i < D; i++) need[i] = 1;
    need[4] = MAXP + 1;
    run("exhaust", 0);

    // a new start clears fail and runs cleanly (R9)
    for (int i = 0; i < D; i++) need[i] = 1;
    run("again", 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule